// File: doc/BRIEF.md
# Static Memory Access Sequencer with Wait Handling

This block runs single read or write accesses on an external asynchronous static-memory bus for one chip select. An internal requester raises a request with address, write data and direction. The sequencer then walks the access through three timed phases: setup, pulse and hold. The lengths of the phases, the strobe that times each direction and the behaviour of the external wait input are captured from configuration inputs when the request is accepted.

Each direction can be timed by either the chip-select strobe or its own direction strobe (read strobe or write strobe). The timing strobe is asserted only during the pulse phase. The other strobe covers the whole access. The external wait input is active low and is synchronised on chip. It can be ignored. It can also freeze the access in the middle of the pulse, or hold back the end of the pulse until the device is ready. It only acts while the sequencer is in the pulse phase. Read data is sampled on the last pulse cycle. An acknowledge pulse then returns the data to the requester.

Top module: `static_bus_seq`

## Requirements
- R1: For a read, when `cfg_rd_by_strobe`=1 the read strobe is low only during the pulse phase and chip select is low for the whole access. When it is 0 the two roles swap. The write strobe stays high during a read.
- R2: For a write, `cfg_wr_by_strobe` gives the same choice between the write strobe and chip select. `bus_wdata` equals the requested data and `bus_wdata_oe`=1 for every access cycle. The read strobe stays high during a write.
- R3: An access lasts S+P+H cycles, where S is the setup count, P is the pulse count with 0 treated as 1, and H is the hold count. A setup or hold count of 0 skips that phase.
- R4: When the wait mode is 0 (off) or 1 (reserved), `bus_wait_n` has no effect on the access length.
- R5: In wait mode 2 (freeze), a low synchronised wait stops the pulse counter, and the count resumes where it stopped. Wait held low from before the access and released after W observed pulse cycles gives a pulse of P+W+1 cycles.
- R6: In wait mode 3 (ready), the last pulse cycle repeats while the synchronised wait is low. Wait held low and released after W ≥ P observed pulse cycles gives a pulse of W+2 cycles.
- R7: Wait low outside the pulse phase does not lengthen the access.
- R8: In wait modes 2 and 3, a hold count of 0 is raised to 1 cycle. In modes 0 and 1 it is not.
- R9: For a read, `rdata` carries the `bus_rdata` value present at the clock edge that ends the pulse phase. It is valid while `ack` is high.
- R10: `ack` is high for exactly one cycle, in the cycle after the last access cycle. A request held high during an access does not start a new one, and the bus is idle after the acknowledge cycle.
- R11: During and after reset, all strobes are high, `ack`=0 and `bus_wdata_oe`=0.
- R12: `bus_addr` equals the requested address in every cycle of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, accepted only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_setup | input | 6 | Setup length in cycles |
| cfg_pulse | input | 6 | Pulse length in cycles (0 acts as 1) |
| cfg_hold | input | 6 | Hold length in cycles |
| cfg_rd_by_strobe | input | 1 | 1 = read strobe times reads, 0 = chip select |
| cfg_wr_by_strobe | input | 1 | 1 = write strobe times writes, 0 = chip select |
| cfg_wait_mode | input | 2 | 0 off, 1 reserved (off), 2 freeze, 3 ready |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | DATA_W | Bus read data |
| bus_wait_n | input | 1 | External wait, active low, asynchronous |

## Verification
The first access cycle appears after the clock edge that samples the request. Strobes are decoded from registered phase state, so every result is due a fixed number of edges after that, with `ack` coming S+P+H edges after the accept edge. The bench samples on falling edges and counts cycles of each strobe level until `ack`. This compares phase lengths, not absolute times. A wait release takes two synchroniser edges plus one counter edge to act, and this is why the expected frozen and ready pulse lengths are P+W+1 and W+2. Read data on `bus_rdata` changes on every observed pulse cycle, so only a capture on the final pulse edge yields the expected value.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int CNT_W = 6;

    typedef enum logic [1:0] {
        WAIT_OFF    = 2'd0,
        WAIT_RSVD   = 2'd1,
        WAIT_FREEZE = 2'd2,
        WAIT_READY  = 2'd3
    } wait_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] pulse;
        logic [CNT_W-1:0] hold;
    } timing_t;

    typedef struct packed {
        logic rd_by_strobe;
        logic wr_by_strobe;
    } strobe_sel_t;

    function automatic logic wait_used(input wait_mode_e m);
        return (m == WAIT_FREEZE) || (m == WAIT_READY);
    endfunction

    function automatic logic [CNT_W-1:0] eff_pulse(input logic [CNT_W-1:0] p);
        return (p == '0) ? CNT_W'(1) : p;
    endfunction

    function automatic logic [CNT_W-1:0] eff_hold(input logic [CNT_W-1:0] h,
                                                   input logic used);
        return (used && h == '0) ? CNT_W'(1) : h;
    endfunction

endpackage

// File: rtl/sbs_wait_sync.sv
module sbs_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sbs_phase_ctrl.sv
module sbs_phase_ctrl
    import sbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  timing_t    tim_in,
    input  wait_mode_e wmode_in,
    input  logic       wait_ok,
    output phase_e     phase,
    output logic       leave_pulse
);
    timing_t          tim_q;
    wait_mode_e       wm_q;
    logic [CNT_W-1:0] cnt, cnt_nx, plen, hlen;
    phase_e           phase_nx;
    logic             freeze, stall, p_end;

    always_comb begin
        plen   = eff_pulse(tim_q.pulse);
        hlen   = eff_hold(tim_q.hold, wait_used(wm_q));
        p_end  = (cnt == plen - CNT_W'(1));
        freeze = (phase == PH_PULSE) && (wm_q == WAIT_FREEZE) && !wait_ok;
        stall  = (phase == PH_PULSE) && (wm_q == WAIT_READY) && !wait_ok && p_end;
        leave_pulse = (phase == PH_PULSE) && p_end && !freeze && !stall;
    end

    always_comb begin
        phase_nx = phase;
        cnt_nx   = cnt;
        unique case (phase)
            PH_IDLE: begin
                if (start) begin
                    cnt_nx   = '0;
                    phase_nx = (tim_in.setup != '0) ? PH_SETUP : PH_PULSE;
                end
            end
            PH_SETUP: begin
                if (cnt == tim_q.setup - CNT_W'(1)) begin
                    cnt_nx   = '0;
                    phase_nx = PH_PULSE;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            PH_PULSE: begin
                if (leave_pulse) begin
                    cnt_nx   = '0;
                    phase_nx = (hlen != '0) ? PH_HOLD : PH_DONE;
                end else if (!freeze && !stall) begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (cnt == hlen - CNT_W'(1)) begin
                    cnt_nx   = '0;
                    phase_nx = PH_DONE;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            PH_DONE:  phase_nx = PH_IDLE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            tim_q <= '0;
            wm_q  <= WAIT_OFF;
        end else begin
            phase <= phase_nx;
            cnt   <= cnt_nx;
            if (phase == PH_IDLE && start) begin
                tim_q <= tim_in;
                wm_q  <= wmode_in;
            end
        end
    end

    // R5: a frozen pulse neither advances nor leaves
    assert_freeze_holds_R5: assert property (@(posedge clk) disable iff (rst)
        freeze |=> (phase == PH_PULSE) && (cnt == $past(cnt)));

    // R6: a ready stall keeps the last pulse cycle
    assert_ready_stall_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> (phase == PH_PULSE));

    // R4: with wait unused the pulse counter always advances
    assert_wait_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PULSE && !wait_used(wm_q) && !p_end)
        |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R8: with wait in use the pulse is always followed by hold
    assert_hold_floor_R8: assert property (@(posedge clk) disable iff (rst)
        (leave_pulse && wait_used(wm_q)) |=> (phase == PH_HOLD));

    // R10: the completion state lasts one cycle
    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |=> (phase == PH_IDLE));
endmodule

// File: rtl/sbs_strobe_gen.sv
module sbs_strobe_gen
    import sbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  phase_e      phase,
    input  logic        is_write,
    input  strobe_sel_t sel,
    output logic        cs_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic        wdata_oe
);
    logic busy, in_pulse, by_strobe, dir_on, cs_on;

    always_comb begin
        busy      = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
        in_pulse  = (phase == PH_PULSE);
        by_strobe = is_write ? sel.wr_by_strobe : sel.rd_by_strobe;
        dir_on    = by_strobe ? in_pulse : busy;
        cs_on     = by_strobe ? busy : in_pulse;
        cs_n      = !cs_on;
        rd_n      = !(dir_on && !is_write);
        wr_n      = !(dir_on && is_write);
        wdata_oe  = busy && is_write;
    end

    // R1: read and write strobes are never low together
    assert_one_dir_R1: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R11: nothing is driven while idle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (cs_n && rd_n && wr_n && !wdata_oe));
endmodule

// File: rtl/static_bus_seq.sv
module static_bus_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_pulse,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              cfg_rd_by_strobe,
    input  logic              cfg_wr_by_strobe,
    input  logic [1:0]        cfg_wait_mode,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_wait_n
);
    phase_e      phase;
    logic        accept, leave_pulse, wait_ok, write_q;
    timing_t     tim_in;
    strobe_sel_t sel_q;

    assign tim_in = '{setup: cfg_setup, pulse: cfg_pulse, hold: cfg_hold};
    assign accept = req && (phase == PH_IDLE);

    sbs_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (bus_wait_n),
        .dout (wait_ok)
    );

    sbs_phase_ctrl u_phase (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .tim_in      (tim_in),
        .wmode_in    (wait_mode_e'(cfg_wait_mode)),
        .wait_ok     (wait_ok),
        .phase       (phase),
        .leave_pulse (leave_pulse)
    );

    sbs_strobe_gen u_strobe (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .is_write (write_q),
        .sel      (sel_q),
        .cs_n     (bus_cs_n),
        .rd_n     (bus_rd_n),
        .wr_n     (bus_wr_n),
        .wdata_oe (bus_wdata_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            write_q   <= 1'b0;
            sel_q     <= '0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rdata     <= '0;
        end else begin
            if (accept) begin
                write_q   <= req_write;
                sel_q     <= '{rd_by_strobe: cfg_rd_by_strobe,
                              wr_by_strobe: cfg_wr_by_strobe};
                bus_addr  <= req_addr;
                bus_wdata <= req_wdata;
            end
            if (leave_pulse && !write_q)
                rdata <= bus_rdata;
        end
    end

    assign ack = (phase == PH_DONE);

    // R10: acknowledge never lasts two cycles
    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R12: address is steady from one access cycle to the next
    assert_addr_steady_R12: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && phase != PH_DONE && $past(phase) != PH_IDLE)
        |-> $stable(bus_addr));

    // R9: read data only changes when the pulse ends
    assert_rdata_capture_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(leave_pulse) |-> $stable(rdata));
endmodule

// File: tb/static_bus_seq_tb.sv
module static_bus_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [5:0]  cfg_setup = '0, cfg_pulse = '0, cfg_hold = '0;
    logic        cfg_rd_by_strobe = 1'b0, cfg_wr_by_strobe = 1'b0;
    logic [1:0]  cfg_wait_mode = '0;
    logic        ack, bus_cs_n, bus_rd_n, bus_wr_n, bus_wdata_oe;
    logic [15:0] rdata, bus_addr, bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_wait_n = 1'b1;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    int r_tot, r_cs, r_dir, r_pc, r_oe, r_badaddr, r_badwd, r_other;
    logic [15:0] r_rd;

    always #10 clk = ~clk;

    static_bus_seq u_dut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
        .cfg_rd_by_strobe(cfg_rd_by_strobe), .cfg_wr_by_strobe(cfg_wr_by_strobe),
        .cfg_wait_mode(cfg_wait_mode), .ack(ack), .rdata(rdata),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
        .bus_rdata(bus_rdata), .bus_wait_n(bus_wait_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // wctl: 0 wait high, 1 low then release after wpar pulse cycles,
    //       2 low from first hold cycle, 3 low throughout
    task automatic do_access(input bit wr, input logic [15:0] addr, input logic [15:0] data,
                             input int s, input int p, input int h,
                             input bit rdby, input bit wrby, input logic [1:0] wm,
                             input int wctl, input int wpar, input bit keep_req);
        bit ctrl_low, dir_low, other_low, got;
        int n;
        r_tot = 0; r_cs = 0; r_dir = 0; r_pc = 0; r_oe = 0;
        r_badaddr = 0; r_badwd = 0; r_other = 0; r_rd = '0;
        bus_wait_n = (wctl == 1 || wctl == 3) ? 1'b0 : 1'b1;
        bus_rdata  = 16'hFFFF;
        repeat (4) @(negedge clk);
        cfg_setup = 6'(s); cfg_pulse = 6'(p); cfg_hold = 6'(h);
        cfg_rd_by_strobe = rdby; cfg_wr_by_strobe = wrby; cfg_wait_mode = wm;
        req_write = wr; req_addr = addr; req_wdata = data; req = 1'b1;
        got = 0; n = 0;
        while (!got) begin
            @(negedge clk);
            n++;
            if (n > 400) begin
                n_chk++; n_err++;
                $display("FAIL R10 access hung actual=no_ack expected=ack");
                got = 1;
            end else if (ack) begin
                got = 1;
                r_rd = rdata;
            end else begin
                r_tot++;
                dir_low   = wr ? !bus_wr_n : !bus_rd_n;
                other_low = wr ? !bus_rd_n : !bus_wr_n;
                if (!bus_cs_n) r_cs++;
                if (dir_low) r_dir++;
                if (other_low) r_other++;
                if (bus_wdata_oe) r_oe++;
                if (bus_addr !== addr) r_badaddr++;
                if (wr && bus_wdata !== data) r_badwd++;
                ctrl_low = (wr ? wrby : rdby) ? dir_low : !bus_cs_n;
                if (ctrl_low) begin
                    r_pc++;
                    bus_rdata = data + 16'(r_pc);
                    if (wctl == 1 && r_pc == wpar) bus_wait_n = 1'b1;
                end else if (wctl == 2 && r_pc > 0) begin
                    bus_wait_n = 1'b0;
                end
                if (!keep_req) req = 1'b0;
            end
        end
        req = 1'b0;
        bus_wait_n = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 strobes high in reset", {bus_cs_n, bus_rd_n, bus_wr_n}, 3'b111);
        chk("R11 ack/oe low in reset", {ack, bus_wdata_oe}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R11 idle after reset", {bus_cs_n, bus_rd_n, bus_wr_n, ack, bus_wdata_oe}, 5'b11100);
    endtask

    task automatic t_read_strobe;
        do_access(0, 16'h1234, 16'hA000, 2, 3, 1, 1, 0, 2'd0, 0, 0, 0);
        chk("R3 read total cycles", r_tot, 6);
        chk("R1 cs low whole access", r_cs, 6);
        chk("R1 rd strobe pulse only", r_dir, 3);
        chk("R1 wr strobe idle on read", r_other, 0);
        chk("R9 read data at pulse end", r_rd, 16'hA003);
        chk("R12 address held", r_badaddr, 0);
    endtask

    task automatic t_read_cs;
        do_access(0, 16'h00F0, 16'hB000, 1, 2, 2, 0, 0, 2'd0, 0, 0, 0);
        chk("R1 cs-timed read cs cycles", r_cs, 2);
        chk("R1 cs-timed read rd cycles", r_dir, 5);
        chk("R9 cs-timed read data", r_rd, 16'hB002);
    endtask

    task automatic t_write_strobe;
        do_access(1, 16'h0A0A, 16'h5A5A, 1, 4, 2, 0, 1, 2'd0, 0, 0, 0);
        chk("R3 write total cycles", r_tot, 7);
        chk("R2 cs low whole write", r_cs, 7);
        chk("R2 wr strobe pulse only", r_dir, 4);
        chk("R2 data drive cycles", r_oe, 7);
        chk("R2 data value", r_badwd, 0);
        chk("R2 rd strobe idle on write", r_other, 0);
        chk("R12 write address held", r_badaddr, 0);
    endtask

    task automatic t_write_cs;
        do_access(1, 16'h0003, 16'h0F0F, 0, 1, 0, 0, 0, 2'd0, 0, 0, 0);
        chk("R3 minimal write total", r_tot, 1);
        chk("R2 cs-timed write cs cycles", r_cs, 1);
        chk("R2 cs-timed write wr cycles", r_dir, 1);
    endtask

    task automatic t_zero_phases;
        do_access(0, 16'h0044, 16'hC000, 0, 0, 0, 1, 0, 2'd0, 0, 0, 0);
        chk("R3 zero counts give one cycle", r_tot, 1);
        chk("R3 zero pulse acts as one", r_pc, 1);
        chk("R9 single-cycle read data", r_rd, 16'hC001);
    endtask

    task automatic t_disabled;
        do_access(0, 16'h0100, 16'hD000, 1, 2, 1, 1, 0, 2'd0, 3, 0, 0);
        chk("R4 mode off ignores wait", r_tot, 4);
        do_access(0, 16'h0101, 16'hD100, 1, 2, 0, 1, 0, 2'd1, 3, 0, 0);
        chk("R4 reserved mode ignores wait", r_tot, 3);
    endtask

    task automatic t_frozen;
        do_access(0, 16'h0200, 16'hE000, 1, 3, 1, 1, 0, 2'd2, 1, 2, 0);
        chk("R5 frozen pulse length", r_pc, 6);
        chk("R5 frozen total", r_tot, 8);
        chk("R9 frozen read data", r_rd, 16'hE006);
    endtask

    task automatic t_ready;
        do_access(0, 16'h0300, 16'h7000, 1, 2, 1, 1, 0, 2'd3, 1, 3, 0);
        chk("R6 ready pulse length", r_pc, 5);
        chk("R6 ready total", r_tot, 7);
        chk("R9 ready read data", r_rd, 16'h7005);
        do_access(1, 16'h0301, 16'h1111, 0, 2, 2, 0, 0, 2'd3, 1, 4, 0);
        chk("R6 ready cs-timed write pulse", r_pc, 6);
        chk("R6 ready cs-timed write total", r_tot, 8);
    endtask

    task automatic t_outside;
        do_access(0, 16'h0400, 16'h2000, 1, 2, 4, 1, 0, 2'd2, 2, 0, 0);
        chk("R7 wait in hold no stretch", r_tot, 7);
        chk("R7 pulse unchanged", r_pc, 2);
    endtask

    task automatic t_hold_min;
        do_access(0, 16'h0500, 16'h3000, 1, 2, 0, 1, 0, 2'd3, 0, 0, 0);
        chk("R8 ready mode forced hold", r_tot, 4);
        do_access(0, 16'h0501, 16'h3100, 1, 2, 0, 1, 0, 2'd2, 0, 0, 0);
        chk("R8 frozen mode forced hold", r_tot, 4);
        do_access(0, 16'h0502, 16'h3200, 1, 2, 0, 1, 0, 2'd0, 0, 0, 0);
        chk("R8 mode off no forced hold", r_tot, 3);
    endtask

    task automatic t_req_held;
        int busy_cycles;
        do_access(0, 16'h0600, 16'h4000, 1, 1, 1, 1, 0, 2'd0, 0, 0, 1);
        chk("R10 held request single access", r_tot, 3);
        @(negedge clk);
        chk("R10 ack one cycle", ack, 0);
        busy_cycles = 0;
        for (int i = 0; i < 4; i++) begin
            if (!bus_cs_n || !bus_rd_n) busy_cycles++;
            @(negedge clk);
        end
        chk("R10 idle after ack", busy_cycles, 0);
    endtask

    initial begin
        t_reset();
        t_read_strobe();
        t_read_cs();
        t_write_strobe();
        t_write_cs();
        t_zero_phases();
        t_disabled();
        t_frozen();
        t_ready();
        t_outside();
        t_hold_min();
        t_req_held();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule